// File: doc/BRIEF.md
# Read-Port Reset and Power-Up Value Emulation

This block sits after the data output of a synchronous RAM read port that has no reset and no defined power-up contents. It makes that port look like one that does. Up to three output multiplexers are cascaded. Each one can replace the RAM data with a fixed constant, and each is steered by a one-bit select flop. The three constants are the power-up value, the asynchronous-reset value and the synchronous-reset value. A select flop loads 1 on every enabled read, so after any reset event the constant stays on the output until the next enabled read lets RAM data through again.

The stages are nested. The power-up stage is innermost, the asynchronous-reset stage comes next, and the synchronous-reset stage drives the output. When two constants are equal, the outer behaviour is folded into the select flop of an inner stage, and the outer multiplexer is not built. A parameter decides whether the synchronous reset acts on its own or only together with the read enable.

Top module: `rd_reset_emu`

## Requirements
- R1: After power-up, before any reset or enabled read, `data_o` equals `INIT_VAL` (with `USE_INIT`=1).
- R2: The first enabled read without synchronous reset makes `data_o` follow `ram_data_i` from the next cycle on.
- R3: While `rst_ni` is low, `data_o` equals `ARST_VAL` without waiting for a clock edge (with `USE_ARST`=1).
- R4: After `rst_ni` is released, `data_o` keeps `ARST_VAL` until the first enabled read. From that read on it shows RAM data.
- R5: With `SRST_GATED`=0, a clock edge with `srst_i`=1 makes `data_o` equal `SRST_VAL` from the next cycle, whatever the value of `en_i`. The value holds until an enabled read that has `srst_i`=0.
- R6: With `SRST_GATED`=1, `srst_i` has no effect on an edge where `en_i`=0. On an edge where `en_i`=1 it loads `SRST_VAL`.
- R7: While `rst_ni` is low, `srst_i` and `en_i` do not change `data_o` away from `ARST_VAL`.
- R8: On an edge with `en_i`=0 and no effective synchronous reset, `data_o` keeps its value, provided the RAM data is stable.
- R9: After an edge with `en_i`=1 and no effective synchronous reset, `data_o` equals `ram_data_i`.
- R10: When constants are equal, one multiplexer serves both. The observable behaviour across random reset, enable and read sequences is identical to a RAM port with native power-up, asynchronous and synchronous reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Read port clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Read enable |
| srst_i | input | 1 | Synchronous reset, active high |
| ram_data_i | input | WIDTH | Registered data output of the RAM read port |
| data_o | output | WIDTH | Read data with reset and power-up values applied |

## Verification
The assertions assume that the RAM data output changes only on a clock edge where `en_i` is high, as a registered read port does. They also assume that `en_i` and `srst_i` are synchronous to `clk_i`, while `rst_ni` may change at any time. The bench drives a register in place of the RAM that captures a new random word only on enabled edges. It changes every input midway between edges, including `rst_ni` assertion and release. Three instances cover distinct constants, a constant shared by the asynchronous and synchronous stages with gating on, and a constant shared by the power-up and asynchronous stages.

// File: rtl/rd_emu_pkg.sv
package rd_emu_pkg;
  localparam int unsigned NUM_STAGES = 3;

  // nesting order, innermost first
  typedef enum logic [1:0] {
    STG_PWRUP = 2'd0,
    STG_ARST  = 2'd1,
    STG_SRST  = 2'd2
  } stage_e;
endpackage

// File: rtl/rd_emu_sel.sv
module rd_emu_sel #(
  parameter bit PWR_SEL  = 1'b0,
  parameter bit HAS_ARST = 1'b1,
  parameter bit ARST_SEL = 1'b0,
  parameter bit HAS_SRST = 1'b1,
  parameter bit SRST_SEL = 1'b0,
  parameter bit GATED    = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic srst_i,
  output logic sel_o
);
  logic arst_n;
  logic srst_hit;
  logic sel_q = PWR_SEL;

  assign arst_n   = HAS_ARST ? rst_ni : 1'b1;
  assign srst_hit = HAS_SRST && srst_i && (en_i || !GATED);

  always_ff @(posedge clk_i or negedge arst_n) begin
    if (!arst_n)       sel_q <= ARST_SEL;
    else if (srst_hit) sel_q <= SRST_SEL;
    else if (en_i)     sel_q <= 1'b1;
  end

  assign sel_o = sel_q;

  // enabled read without sync reset always opens the stage (R9)
  p_sel_open_r9: assert property (@(posedge clk_i) disable iff (!arst_n)
    (en_i && !(HAS_SRST && srst_i)) |=> sel_o);
endmodule

// File: rtl/rd_emu_stage.sv
module rd_emu_stage #(
  parameter int unsigned     WIDTH    = 8,
  parameter logic [WIDTH-1:0] CVAL    = '0,
  parameter bit              PWR_SEL  = 1'b0,
  parameter bit              HAS_ARST = 1'b1,
  parameter bit              ARST_SEL = 1'b0,
  parameter bit              HAS_SRST = 1'b1,
  parameter bit              SRST_SEL = 1'b0,
  parameter bit              GATED    = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             srst_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] d_o
);
  logic sel;

  rd_emu_sel #(
    .PWR_SEL (PWR_SEL),
    .HAS_ARST(HAS_ARST),
    .ARST_SEL(ARST_SEL),
    .HAS_SRST(HAS_SRST),
    .SRST_SEL(SRST_SEL),
    .GATED   (GATED)
  ) u_sel (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .srst_i(srst_i),
    .sel_o (sel)
  );

  assign d_o = sel ? d_i : CVAL;
endmodule

// File: rtl/rd_reset_emu.sv
module rd_reset_emu
  import rd_emu_pkg::*;
#(
  parameter int unsigned      WIDTH      = 8,
  parameter logic [WIDTH-1:0] INIT_VAL   = 8'hA5,
  parameter logic [WIDTH-1:0] ARST_VAL   = 8'h3C,
  parameter logic [WIDTH-1:0] SRST_VAL   = 8'hC3,
  parameter bit               USE_INIT   = 1'b1,
  parameter bit               USE_ARST   = 1'b1,
  parameter bit               USE_SRST   = 1'b1,
  parameter bit               SRST_GATED = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             srst_i,
  input  logic [WIDTH-1:0] ram_data_i,
  output logic [WIDTH-1:0] data_o
);
  // constant sharing between stages
  localparam bit MERGE_AI = USE_INIT && USE_ARST && (ARST_VAL == INIT_VAL);
  localparam bit MERGE_SI = USE_INIT && USE_SRST && (SRST_VAL == INIT_VAL);
  localparam bit MERGE_SA = USE_ARST && !MERGE_AI && USE_SRST && !MERGE_SI
                            && (SRST_VAL == ARST_VAL);

  // per-stage configuration, index = stage_e
  localparam bit [NUM_STAGES-1:0] BUILD  = {USE_SRST && !MERGE_SI && !MERGE_SA,
                                            USE_ARST && !MERGE_AI, USE_INIT};
  localparam bit [NUM_STAGES-1:0] PWR_S  = {1'b1, 1'b1, 1'b0};
  localparam bit [NUM_STAGES-1:0] HAS_AR = {USE_ARST, 1'b1, USE_ARST};
  localparam bit [NUM_STAGES-1:0] AR_S   = {1'b1, 1'b0, !MERGE_AI};
  localparam bit [NUM_STAGES-1:0] HAS_SR = {1'b1, USE_SRST, USE_SRST};
  localparam bit [NUM_STAGES-1:0] SR_S   = {1'b0, !MERGE_SA, !MERGE_SI};

  logic [NUM_STAGES:0][WIDTH-1:0] chain;

  assign chain[0] = ram_data_i;

  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stg
    localparam logic [WIDTH-1:0] CV = (k == int'(STG_PWRUP)) ? INIT_VAL :
                                      (k == int'(STG_ARST))  ? ARST_VAL : SRST_VAL;
    if (BUILD[k]) begin : g_on
      rd_emu_stage #(
        .WIDTH   (WIDTH),
        .CVAL    (CV),
        .PWR_SEL (PWR_S[k]),
        .HAS_ARST(HAS_AR[k]),
        .ARST_SEL(AR_S[k]),
        .HAS_SRST(HAS_SR[k]),
        .SRST_SEL(SR_S[k]),
        .GATED   (SRST_GATED)
      ) u_stage (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .en_i  (en_i),
        .srst_i(srst_i),
        .d_i   (chain[k]),
        .d_o   (chain[k+1])
      );
    end else begin : g_off
      assign chain[k+1] = chain[k];
    end
  end

  assign data_o = chain[NUM_STAGES];

  if (USE_ARST) begin : g_a_arst
    p_arst_out_r3: assert property (@(posedge clk_i)
      !rst_ni |-> (data_o == ARST_VAL));
  end

  if (USE_SRST) begin : g_a_srst
    p_srst_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (srst_i && (en_i || !SRST_GATED)) |=> (data_o == SRST_VAL));
  end

  p_read_pass_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !(USE_SRST && srst_i)) |=> (data_o == ram_data_i));

  p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !(USE_SRST && srst_i && !SRST_GATED))
      |=> ($stable(ram_data_i) -> $stable(data_o)));
endmodule

// File: tb/tb_rd_reset_emu.sv
module tb_rd_reset_emu;
  localparam int W = 8;
  // instance dut: distinct constants, ungated sync reset
  localparam logic [W-1:0] I0 = 8'hA5, A0 = 8'h3C, S0 = 8'hC3;
  // instance dut_g: async and sync share a constant, gated sync reset
  localparam logic [W-1:0] I1 = 8'h11, A1 = 8'h22, S1 = 8'h22;
  // instance dut_a: power-up and async share a constant, ungated
  localparam logic [W-1:0] I2 = 8'h33, A2 = 8'h33, S2 = 8'h44;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic en = 1'b0;
  logic srst = 1'b0;
  logic [W-1:0] word = '0;
  logic [W-1:0] raw = '0;
  logic [W-1:0] q0, q1, q2;
  logic [W-1:0] r0 = I0, r1 = I1, r2 = I2;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  // stand-in for the RAM output register: updates only on enabled reads
  always @(posedge clk) if (en) raw <= word;

  rd_reset_emu #(.WIDTH(W), .INIT_VAL(I0), .ARST_VAL(A0), .SRST_VAL(S0),
    .SRST_GATED(1'b0)) dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .srst_i(srst),
    .ram_data_i(raw), .data_o(q0));

  rd_reset_emu #(.WIDTH(W), .INIT_VAL(I1), .ARST_VAL(A1), .SRST_VAL(S1),
    .SRST_GATED(1'b1)) dut_g (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .srst_i(srst),
    .ram_data_i(raw), .data_o(q1));

  rd_reset_emu #(.WIDTH(W), .INIT_VAL(I2), .ARST_VAL(A2), .SRST_VAL(S2),
    .SRST_GATED(1'b0)) dut_a (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .srst_i(srst),
    .ram_data_i(raw), .data_o(q2));

  // behavioural port with native power-up, async and sync reset
  function automatic logic [W-1:0] nxt(input logic [W-1:0] cur,
                                       input logic [W-1:0] sv, input bit gated);
    if (srst && (en || !gated)) return sv;
    if (en) return word;
    return cur;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r0 <= A0; r1 <= A1; r2 <= A2;
    end else begin
      r0 <= nxt(r0, S0, 1'b0);
      r1 <= nxt(r1, S1, 1'b1);
      r2 <= nxt(r2, S2, 1'b0);
    end
  end

  task automatic check1(string tag, string name, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s t=%0t actual=%h expected=%h", tag, name, $time, act, exp);
    end
  endtask

  task automatic compare(string tag);
    check1(tag, "dut", q0, r0);
    check1(tag, "dut_g", q1, r1);
    check1(tag, "dut_a", q2, r2);
  endtask

  task automatic drive(bit e, bit s, bit rn);
    en = e; srst = s; rst_n = rn; word = W'($urandom);
  endtask

  task automatic tick(string tag);
    @(posedge clk);
    #5;
    compare(tag);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    total++; bad++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    #1;
    compare("R1");                       // power-up values
    check1("R1", "dut_const", q0, I0);
    drive(0, 0, 1); tick("R1"); tick("R8");
    drive(1, 0, 1); tick("R2");
    check1("R2", "dut_raw", q0, raw);
    drive(0, 0, 1); tick("R8"); tick("R8");
    // async reset mid-cycle, seen without a clock edge
    drive(0, 0, 0); #1 compare("R3");
    check1("R3", "dut_const", q0, A0);
    drive(1, 1, 0); tick("R7"); tick("R7");
    check1("R7", "dut_const", q0, A0);
    drive(0, 0, 1); #1 compare("R4");
    tick("R4");
    check1("R4", "dut_const", q0, A0);
    drive(1, 0, 1); tick("R4");
    check1("R4", "dut_raw", q0, raw);
    // sync reset without enable: ungated loads, gated ignores
    drive(0, 1, 1); tick("R5");
    check1("R5", "dut_const", q0, S0);
    check1("R6", "dut_g_raw", q1, raw);
    tick("R5");
    drive(0, 0, 1); tick("R5");
    check1("R5", "dut_hold", q0, S0);
    drive(1, 1, 1); tick("R6");
    check1("R6", "dut_g_const", q1, S1);
    drive(1, 0, 1); tick("R9");
    check1("R9", "dut_g_raw", q1, raw);
    drive(0, 1, 1); tick("R6");
    check1("R6", "dut_g_raw", q1, raw);
    // random sequences against the reference
    for (int i = 0; i < 4000; i++) begin
      bit rn;
      if (rst_n) rn = ($urandom % 25) != 0;
      else       rn = ($urandom % 3) == 0;
      drive(bit'($urandom % 2), ($urandom % 6) == 0, rn);
      tick("R10");
    end
    finish_run();
  end
endmodule